// File: doc/BRIEF.md
# Segmented Transmit Bus Framing Monitor

This block watches a wide transmit bus split into equal segments, four segments of 16 bytes each by default. It never drives the bus and never stalls it. Each segment has its own qualifiers: enable, packet start, packet end, channel number, an empty-lane count and an error mark. On every clock the monitor steps through the segments from index 0 upward. It keeps one open-packet bit for each channel, so packets on different channels can interleave freely. It flags the first framing fault it finds and counts how many packets closed cleanly and how many closed with the error mark.

The monitor also turns each segment's end qualifiers into a per-byte-lane valid mask. Lane k covers segment bits [8k+7:8k], and the first byte of a packet sits in the highest lane. A fault report is a one-cycle pulse with a code and the index of the segment that caused it. Each fault kind also sets a sticky bit that stays set until reset. Every output is registered, so it reflects the bus values sampled one clock earlier.

Top module: `segbus_frame_monitor`

## Requirements
- R1: Synchronous active-high reset clears all outputs, both counters, the sticky bits and every channel's open-packet bit.
- R2: A segment whose enable is low has no effect. Its start, end, error, channel and empty-count inputs change no state and raise no fault, and its lane mask is all zeros.
- R3: A segment that has start and end both set completes a packet. The good counter rises by one when error is low, and the channel is closed afterwards.
- R4: Segments are evaluated in index order. A start in one segment followed by an end on the same channel in a higher segment of the same cycle is legal and completes one packet.
- R5: A start on a channel that already has an open packet is a duplicate-start fault, reported as code 1 and recorded in sticky bit 0. The channel stays open.
- R6: An enabled segment without start, on a channel with no open packet, is a stray-data fault, reported as code 2 and recorded in sticky bit 1. An end flag on such a segment completes nothing and counts nothing.
- R7: An enabled segment without end has all 16 lanes valid, whatever its empty count.
- R8: On an enabled segment with end set and error low, an empty count N marks lanes 0 to N-1 invalid and lanes N to 15 valid.
- R9: When end and error are both set, the low three bits of the empty count are taken as zero and bit 3 is used as given. The packet increments the error counter instead of the good counter.
- R10: When several segments fault in one cycle, the code and segment index reported are those of the lowest-indexed faulting segment. The sticky bits collect every fault kind seen in that cycle.
- R11: Sticky bits are never cleared except by reset.
- R12: Each of the 16 channels, selected by a 4-bit channel field, keeps its open-packet state independently of the others.
- R13: The fault pulse lasts one cycle, appears in the cycle after the faulting bus cycle, and is low with code 0 and segment 0 when the sampled cycle had no fault.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst | input | 1 | Synchronous active-high reset |
| seg_en | input | 4 | Per-segment enable |
| seg_sop | input | 4 | Per-segment packet start |
| seg_eop | input | 4 | Per-segment packet end |
| seg_err | input | 4 | Per-segment error mark, meaningful with end |
| seg_chan | input | 16 | Channel numbers, segment s at bits [4s+3:4s] |
| seg_mty | input | 16 | Empty-lane counts, segment s at bits [4s+3:4s] |
| viol_valid | output | 1 | One-cycle fault pulse |
| viol_code | output | 4 | Fault code: 0 none, 1 duplicate start, 2 stray data |
| viol_seg | output | 2 | Index of the lowest faulting segment |
| sticky_flags | output | 2 | Bit 0 duplicate start seen, bit 1 stray data seen |
| good_count | output | 32 | Packets closed without error mark |
| err_count | output | 32 | Packets closed with error mark |
| lane_valid | output | 64 | Byte-lane valid masks, segment s at bits [16s+15:16s] |

## Verification
Every output has a latency of exactly one clock: what the bus carries before rising edge k shows up on the outputs just after edge k. The bench drives each bus cycle on the falling edge and advances a behavioural model by that one cycle. It then compares every output one nanosecond after the next rising edge, so each comparison covers precisely the cycle just driven. Counters and sticky bits are checked as running totals, which means an effect that arrives a cycle early or late still shows up as a mismatch on the following compare.

// File: rtl/segmon_pkg.sv
package segmon_pkg;

  typedef enum logic [3:0] {
    VC_NONE      = 4'd0,
    VC_DUP_START = 4'd1,
    VC_STRAY     = 4'd2
  } viol_code_e;

  localparam int STICKY_DUP   = 0;
  localparam int STICKY_STRAY = 1;

endpackage

// File: rtl/segmon_step.sv
module segmon_step #(
  parameter int NCHAN  = 16,
  parameter int CHAN_W = 4
) (
  input  logic              en,
  input  logic              sop,
  input  logic              eop,
  input  logic              err,
  input  logic [CHAN_W-1:0] chan,
  input  logic [NCHAN-1:0]  open_in,
  output logic [NCHAN-1:0]  open_out,
  output logic              dup,
  output logic              stray,
  output logic              good_end,
  output logic              bad_end
);

  logic was_open;

  always_comb begin
    was_open = open_in[chan];
    open_out = open_in;
    dup      = 1'b0;
    stray    = 1'b0;
    good_end = 1'b0;
    bad_end  = 1'b0;
    if (en) begin
      if (sop) begin
        dup = was_open;
        if (eop) begin
          open_out[chan] = 1'b0;
          good_end       = ~err;
          bad_end        = err;
        end else begin
          open_out[chan] = 1'b1;
        end
      end else if (!was_open) begin
        stray = 1'b1;
      end else if (eop) begin
        open_out[chan] = 1'b0;
        good_end       = ~err;
        bad_end        = err;
      end
    end
  end

endmodule

// File: rtl/segmon_lanes.sv
module segmon_lanes #(
  parameter int LANES = 16,
  parameter int MTY_W = 4
) (
  input  logic             en,
  input  logic             eop,
  input  logic             err,
  input  logic [MTY_W-1:0] mty,
  output logic [LANES-1:0] vld
);

  localparam logic [MTY_W-1:0] TOP_BIT = MTY_W'(1) << (MTY_W - 1);

  logic [MTY_W-1:0] eff;

  always_comb begin
    eff = err ? (mty & TOP_BIT) : mty;
    for (int k = 0; k < LANES; k++) begin
      vld[k] = en && (!eop || (k >= int'(eff)));
    end
  end

endmodule

// File: rtl/segbus_frame_monitor.sv
module segbus_frame_monitor
  import segmon_pkg::*;
#(
  parameter int SEGS      = 4,
  parameter int SEG_BYTES = 16,
  parameter int CHAN_W    = 4,
  parameter int MTY_W     = 4,
  parameter int CNT_W     = 32,
  localparam int SEG_IDX_W = (SEGS > 1) ? $clog2(SEGS) : 1
) (
  input  logic                      clk,
  input  logic                      rst,
  input  logic [SEGS-1:0]           seg_en,
  input  logic [SEGS-1:0]           seg_sop,
  input  logic [SEGS-1:0]           seg_eop,
  input  logic [SEGS-1:0]           seg_err,
  input  logic [SEGS*CHAN_W-1:0]    seg_chan,
  input  logic [SEGS*MTY_W-1:0]     seg_mty,
  output logic                      viol_valid,
  output logic [3:0]                viol_code,
  output logic [SEG_IDX_W-1:0]      viol_seg,
  output logic [1:0]                sticky_flags,
  output logic [CNT_W-1:0]          good_count,
  output logic [CNT_W-1:0]          err_count,
  output logic [SEGS*SEG_BYTES-1:0] lane_valid
);

  localparam int NCHAN = 1 << CHAN_W;

  logic [NCHAN-1:0] open_q;
  logic [NCHAN-1:0] chain [SEGS+1];
  logic [SEGS-1:0]  dup_v, stray_v, good_v, bad_v;
  logic [SEGS*SEG_BYTES-1:0] lane_d;

  assign chain[0] = open_q;

  for (genvar g = 0; g < SEGS; g++) begin : g_seg
    segmon_step #(.NCHAN(NCHAN), .CHAN_W(CHAN_W)) u_step (
      .en       (seg_en[g]),
      .sop      (seg_sop[g]),
      .eop      (seg_eop[g]),
      .err      (seg_err[g]),
      .chan     (seg_chan[g*CHAN_W +: CHAN_W]),
      .open_in  (chain[g]),
      .open_out (chain[g+1]),
      .dup      (dup_v[g]),
      .stray    (stray_v[g]),
      .good_end (good_v[g]),
      .bad_end  (bad_v[g])
    );

    segmon_lanes #(.LANES(SEG_BYTES), .MTY_W(MTY_W)) u_lanes (
      .en  (seg_en[g]),
      .eop (seg_eop[g]),
      .err (seg_err[g]),
      .mty (seg_mty[g*MTY_W +: MTY_W]),
      .vld (lane_d[g*SEG_BYTES +: SEG_BYTES])
    );

    // R8: valid lanes always form one block that reaches the top lane
    p_lane_shape_r8: assert property (@(posedge clk) disable iff (rst)
      ((~lane_valid[g*SEG_BYTES +: SEG_BYTES]) &
       ((~lane_valid[g*SEG_BYTES +: SEG_BYTES]) + 1'b1)) == '0);

    // R2: an idle segment yields an empty mask one cycle later
    p_idle_lanes_r2: assert property (@(posedge clk) disable iff (rst)
      !$past(seg_en[g]) |-> (lane_valid[g*SEG_BYTES +: SEG_BYTES] == '0));
  end

  logic                 any_viol;
  viol_code_e           code_d;
  logic [SEG_IDX_W-1:0] seg_d;
  logic [CNT_W-1:0]     good_inc, bad_inc;

  always_comb begin
    any_viol = |(dup_v | stray_v);
    code_d   = VC_NONE;
    seg_d    = '0;
    for (int s = SEGS - 1; s >= 0; s--) begin
      if (dup_v[s] || stray_v[s]) begin
        code_d = dup_v[s] ? VC_DUP_START : VC_STRAY;
        seg_d  = SEG_IDX_W'(s);
      end
    end
    good_inc = '0;
    bad_inc  = '0;
    for (int s = 0; s < SEGS; s++) begin
      good_inc = good_inc + CNT_W'(good_v[s]);
      bad_inc  = bad_inc + CNT_W'(bad_v[s]);
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      open_q       <= '0;
      viol_valid   <= 1'b0;
      viol_code    <= 4'd0;
      viol_seg     <= '0;
      sticky_flags <= '0;
      good_count   <= '0;
      err_count    <= '0;
      lane_valid   <= '0;
    end else begin
      open_q       <= chain[SEGS];
      viol_valid   <= any_viol;
      viol_code    <= code_d;
      viol_seg     <= seg_d;
      sticky_flags[STICKY_DUP]   <= sticky_flags[STICKY_DUP] | (|dup_v);
      sticky_flags[STICKY_STRAY] <= sticky_flags[STICKY_STRAY] | (|stray_v);
      good_count   <= good_count + good_inc;
      err_count    <= err_count + bad_inc;
      lane_valid   <= lane_d;
    end
  end

  // R13: a pulse always carries a defined nonzero code
  p_code_defined_r13: assert property (@(posedge clk) disable iff (rst)
    viol_valid |-> (viol_code == 4'd1 || viol_code == 4'd2));

  // R13: no pulse means code and index are both zero
  p_quiet_zero_r13: assert property (@(posedge clk) disable iff (rst)
    !viol_valid |-> (viol_code == 4'd0 && viol_seg == '0));

  // R11: sticky bits only ever gain set bits
  p_sticky_hold_r11: assert property (@(posedge clk) disable iff (rst)
    (sticky_flags & $past(sticky_flags)) == $past(sticky_flags));

  // R10: a reported fault has its kind recorded as sticky
  p_pulse_sticky_r10: assert property (@(posedge clk) disable iff (rst)
    (viol_valid && viol_code == 4'd1) |-> sticky_flags[STICKY_DUP]);

  // R3: at most one completion per segment per cycle
  p_count_step_r3: assert property (@(posedge clk) disable iff (rst)
    (good_count - $past(good_count)) <= CNT_W'(SEGS));

  // R9: the same bound holds for error completions
  p_err_step_r9: assert property (@(posedge clk) disable iff (rst)
    (err_count - $past(err_count)) <= CNT_W'(SEGS));

endmodule

// File: tb/sim_segbus_frame_monitor.sv
module sim_segbus_frame_monitor;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic [3:0]  seg_en = '0, seg_sop = '0, seg_eop = '0, seg_err = '0;
  logic [15:0] seg_chan = '0, seg_mty = '0;
  logic        viol_valid;
  logic [3:0]  viol_code;
  logic [1:0]  viol_seg;
  logic [1:0]  sticky_flags;
  logic [31:0] good_count, err_count;
  logic [63:0] lane_valid;

  always #2 clk = ~clk;

  segbus_frame_monitor u0 (
    .clk(clk), .rst(rst), .seg_en(seg_en), .seg_sop(seg_sop),
    .seg_eop(seg_eop), .seg_err(seg_err), .seg_chan(seg_chan),
    .seg_mty(seg_mty), .viol_valid(viol_valid), .viol_code(viol_code),
    .viol_seg(viol_seg), .sticky_flags(sticky_flags),
    .good_count(good_count), .err_count(err_count), .lane_valid(lane_valid)
  );

  int checks = 0;
  int errors = 0;
  bit done   = 1'b0;

  // behavioural reference state
  bit          m_open [16];
  bit          e_vv;
  int          e_code, e_seg;
  bit [1:0]    e_sticky;
  int unsigned e_good, e_bad;
  bit [63:0]   e_lane;

  task automatic chk(input string tag, input string what,
                     input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s %s: actual %0h expected %0h", tag, what, act, exp);
    end
  endtask

  task automatic compare_all(input string tag);
    chk(tag, "viol_valid", 64'(viol_valid), 64'(e_vv));
    chk(tag, "viol_code", 64'(viol_code), 64'(e_code));
    chk(tag, "viol_seg", 64'(viol_seg), 64'(e_seg));
    chk(tag, "sticky", 64'(sticky_flags), 64'(e_sticky));
    chk(tag, "good_count", 64'(good_count), 64'(e_good));
    chk(tag, "err_count", 64'(err_count), 64'(e_bad));
    chk(tag, "lane_valid", lane_valid, e_lane);
  endtask

  task automatic model_clear();
    foreach (m_open[i]) m_open[i] = 1'b0;
    e_vv = 0; e_code = 0; e_seg = 0; e_sticky = '0;
    e_good = 0; e_bad = 0; e_lane = '0;
  endtask

  task automatic model_step(input logic [3:0] en, sop, eop, err,
                            input logic [15:0] chan, mty);
    bit first = 1'b1;
    e_vv = 0; e_code = 0; e_seg = 0; e_lane = '0;
    for (int s = 0; s < 4; s++) begin
      int c   = int'(chan[s*4 +: 4]);
      int m   = int'(mty[s*4 +: 4]);
      int kind = 0;
      if (en[s]) begin
        if (sop[s]) begin
          if (m_open[c]) kind = 1;
          if (eop[s]) begin
            m_open[c] = 1'b0;
            if (err[s]) e_bad++; else e_good++;
          end else m_open[c] = 1'b1;
        end else if (!m_open[c]) begin
          kind = 2;
        end else if (eop[s]) begin
          m_open[c] = 1'b0;
          if (err[s]) e_bad++; else e_good++;
        end
        if (eop[s] && err[s]) m = m & 8;
        for (int k = 0; k < 16; k++)
          e_lane[s*16 + k] = (!eop[s]) || (k >= m);
      end
      if (kind != 0) begin
        e_sticky[kind-1] = 1'b1;
        if (first) begin
          first  = 1'b0;
          e_vv   = 1'b1;
          e_code = kind;
          e_seg  = s;
        end
      end
    end
  endtask

  task automatic cyc(input logic [3:0] en, sop, eop, err,
                     input logic [15:0] chan, mty, input string tag);
    @(negedge clk);
    seg_en = en; seg_sop = sop; seg_eop = eop; seg_err = err;
    seg_chan = chan; seg_mty = mty;
    model_step(en, sop, eop, err, chan, mty);
    @(posedge clk);
    #1;
    compare_all(tag);
  endtask

  task automatic do_reset();
    @(negedge clk);
    rst = 1'b1;
    seg_en = '0; seg_sop = '0; seg_eop = '0; seg_err = '0;
    seg_chan = '0; seg_mty = '0;
    model_clear();
    @(posedge clk);
    @(posedge clk);
    #1;
    compare_all("R1");
    @(negedge clk);
    rst = 1'b0;
  endtask

  initial begin
    #(4 * 200000);
    if (!done) begin
      errors++;
      $display("FAIL watchdog: actual hung expected finish");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    do_reset();
    // R3: single-segment packet on channel 3, five empty lanes
    cyc(4'b0001, 4'b0001, 4'b0001, 4'b0000, 16'h0003, 16'h0005, "R3");
    // R2: disabled segments with every other qualifier set
    cyc(4'b0000, 4'b1111, 4'b1111, 4'b1111, 16'h5A3C, 16'hFFFF, "R2");
    // R4: start seg1, body seg2, end seg3, channel 7
    cyc(4'b1110, 4'b0010, 4'b1000, 4'b0000, 16'h7770, 16'h3000, "R4");
    // R7: open channel 2, nonzero empty counts without end
    cyc(4'b0011, 4'b0001, 4'b0000, 4'b0000, 16'h0022, 16'h00F9, "R7");
    // R8: close channel 2 with twelve empty lanes
    cyc(4'b0001, 4'b0000, 4'b0001, 4'b0000, 16'h0002, 16'h000C, "R8");
    // R9: errored ends, count 0xF becomes 8 and 0x5 becomes 0
    cyc(4'b0011, 4'b0011, 4'b0011, 4'b0011, 16'h0041, 16'h005F, "R9");
    // R5: duplicate start on channel 5
    cyc(4'b0001, 4'b0001, 4'b0000, 4'b0000, 16'h0005, 16'h0000, "R5");
    cyc(4'b0100, 4'b0100, 4'b0000, 4'b0000, 16'h0500, 16'h0000, "R5");
    // R13: quiet cycle after a fault drops the pulse
    cyc(4'b0000, 4'b0000, 4'b0000, 4'b0000, 16'h0000, 16'h0000, "R13");
    // R6: stray data with end on closed channel 9
    cyc(4'b0001, 4'b0000, 4'b0001, 4'b0000, 16'h0009, 16'h0000, "R6");
    // R10: stray on seg1 beats duplicate on seg3
    cyc(4'b1010, 4'b1000, 4'b0000, 4'b0000, 16'h50A0, 16'h0000, "R10");
    // R11: clean close of channel 5, sticky bits remain
    cyc(4'b0001, 4'b0000, 4'b0001, 4'b0000, 16'h0005, 16'h0000, "R11");
    // R12: four channels open together, closed in reverse segment order
    cyc(4'b1111, 4'b1111, 4'b0000, 4'b0000, 16'hCBA8, 16'h0000, "R12");
    cyc(4'b1111, 4'b0000, 4'b1111, 4'b0100, 16'h8ABC, 16'h1234, "R12");
    for (int n = 0; n < 400; n++) begin
      logic [15:0] ch;
      ch = $urandom() & 16'h3333;
      cyc(4'($urandom()), 4'($urandom()), 4'($urandom()), 4'($urandom()),
          ch, 16'($urandom()), "R12");
    end
    // R1: reset clears sticky bits, counters and channel state
    do_reset();
    cyc(4'b0001, 4'b0000, 4'b0000, 4'b0000, 16'h0003, 16'h0000, "R1");
    cyc(4'b0000, 4'b0000, 4'b0000, 4'b0000, 16'h0000, 16'h0000, "R13");
    done = 1'b1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

endmodule